// File: doc/BRIEF.md
# Banked Video Memory Window Controller

This block sits between a byte-wide CPU bus and the memories behind an 8 KB data window. The window runs from 0xC000 to 0xDFFE. A mode register picks where each window access goes. The targets are one of two 8 KB video RAM pages, a 2 KB auxiliary RAM, or a read-only view into a large graphics ROM. The graphics-ROM view is steered by its own select register, and it wins over every other mapping on reads.

The block also holds the program ROM bank number and a write-enable bit. Both come from a bank-switch register at 0xF480. A control bit in that same register starts a hardware fill. The fill engine writes one byte per clock over an entire video page. The target page and the fill byte are the values the CPU last stored at auxiliary RAM offsets 0 and 1. While a fill runs, the video RAM port belongs to the engine and CPU video RAM accesses are shut out.

All memories are external and synchronous. CPU read data appears on `cpu_rdata` in the clock cycle after the read strobe is sampled.

Top module: `vwin_ctrl`

## Requirements
- R1: Only addresses 0xC000 to 0xDFFE form the data window. A write to 0xDFFF loads the mode register and reaches no memory. A read outside the window returns 0x00.
- R2: When the ROM-select register (written at 0xF500) is nonzero and the window offset is below 0x1000, a read returns the ROM byte at address ((select & 0x7F) << 12) + offset. This takes priority over every other read mapping.
- R3: With mode 0, window reads and writes reach offset `offset` of the video page chosen by the page bit.
- R4: With mode 2 and an offset below 0x800, window accesses reach the auxiliary RAM. With mode 2 and an offset of 0x800 or above, reads return 0x00.
- R5: With mode 3, a window write to offset 0 whose data bits [7:1] are all zero sets the page bit to data bit 0. Any other write in mode 3 leaves the page bit unchanged.
- R6: Writes to video or auxiliary RAM take effect only while bit 7 of the bank-switch register is 1.
- R7: `prog_bank` equals bits [3:0] of the last value written to 0xF480.
- R8: A write to 0xF480 with bit 6 set, while no fill is running, fills all 8192 bytes of video page (aux[0] & 1) with aux[1]. `fill_busy` is 1 for exactly 8192 cycles, starting the cycle after that write. A trigger written while a fill is running is ignored.
- R9: Window reads in a mode other than 0, 2 or 3, and reads in mode 3, return 0x00.
- R10: While `fill_busy` is 1, CPU window reads in mode 0 return 0x00 and CPU writes in mode 0 are dropped.
- R11: After reset the mode, page, ROM-select and bank-switch registers are zero, `prog_bank` is 0 and `fill_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| prog_bank | output | 4 | Program ROM bank number |
| fill_busy | output | 1 | Page fill in progress |
| vram_page | output | 1 | Video RAM page select |
| vram_addr | output | 13 | Video RAM byte address |
| vram_we | output | 1 | Video RAM write enable |
| vram_wdata | output | 8 | Video RAM write data |
| vram_rdata | input | 8 | Video RAM read data (one cycle latency) |
| aux_addr | output | 11 | Auxiliary RAM address |
| aux_we | output | 1 | Auxiliary RAM write enable |
| aux_wdata | output | 8 | Auxiliary RAM write data |
| aux_rdata | input | 8 | Auxiliary RAM read data (one cycle latency) |
| rom_addr | output | 19 | Graphics ROM byte address |
| rom_rdata | input | 8 | Graphics ROM data (one cycle latency) |

## Verification
The window is exercised with reads and writes in each mode value: 0, 1, 2 and 3. This separates correct routing from a decoder that merges neighbouring modes. Offsets are chosen on both sides of the 0x800 and 0x1000 limits, so an off-by-one in the range checks shows up as wrong data. The page-select write is tried with data 0x03, with a nonzero offset, and with the legal values 0x00 and 0x01. Data written to one page must stay invisible from the other. The fill is started from auxiliary values the CPU wrote. During the fill, reads, writes and a second trigger are attempted, and afterwards both pages are read back. This tells apart a wrong target page, a wrong fill length, and blocking that leaks.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
    localparam int MODE_VRAM = 0;
    localparam int MODE_AUX  = 2;
    localparam int MODE_PSEL = 3;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_VRAM = 2'd1,
        SRC_AUX  = 2'd2,
        SRC_ROM  = 2'd3
    } rd_src_e;
endpackage

// File: rtl/vwin_regs.sv
module vwin_regs #(
    parameter int DATA_W  = 8,
    parameter int PAGE_AW = 13,
    parameter int AUX_AW  = 11,
    parameter int PBANK_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_wr,
    input  logic [PAGE_AW-1:0] win_off,
    input  logic               ctl_wr,
    input  logic               bsw_wr,
    input  logic               sel_wr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  bankctl,
    output logic [DATA_W-1:0]  romsel,
    output logic [PBANK_W-1:0] pbank,
    output logic               wen,
    output logic               page,
    output logic               psel_hit,
    output logic               fill_start,
    output logic               shd_page,
    output logic [DATA_W-1:0]  shd_val
);
    import vwin_pkg::*;

    localparam int WEN_BIT   = DATA_W - 1;
    localparam int FILL_BIT  = DATA_W - 2;
    localparam int AUX_DEPTH = 1 << AUX_AW;
    localparam logic [DATA_W-1:0] PSEL_C = DATA_W'(MODE_PSEL);
    localparam logic [DATA_W-1:0] AUX_C  = DATA_W'(MODE_AUX);

    typedef struct packed {
        logic [DATA_W-1:0]  bankctl;
        logic [DATA_W-1:0]  romsel;
        logic [PBANK_W-1:0] pbank;
        logic               wen;
        logic               page;
        logic               shd_page;
        logic [DATA_W-1:0]  shd_val;
    } regs_t;

    regs_t q, d;
    logic  aux_wr_ok;

    always_comb begin
        d          = q;
        psel_hit   = win_wr && (q.bankctl == PSEL_C) && (win_off == '0)
                     && (wdata[DATA_W-1:1] == '0);
        aux_wr_ok  = win_wr && (q.bankctl == AUX_C) && q.wen
                     && (win_off < PAGE_AW'(AUX_DEPTH));
        fill_start = bsw_wr && wdata[FILL_BIT];
        if (ctl_wr) d.bankctl = wdata;
        if (sel_wr) d.romsel  = wdata;
        if (bsw_wr) begin
            d.pbank = wdata[PBANK_W-1:0];
            d.wen   = wdata[WEN_BIT];
        end
        if (psel_hit) begin
            d.page = wdata[0];
        end else if (aux_wr_ok) begin
            if (win_off == PAGE_AW'(0)) d.shd_page = wdata[0];
            if (win_off == PAGE_AW'(1)) d.shd_val  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bankctl  = q.bankctl;
    assign romsel   = q.romsel;
    assign pbank    = q.pbank;
    assign wen      = q.wen;
    assign page     = q.page;
    assign shd_page = q.shd_page;
    assign shd_val  = q.shd_val;

    // R5: page bit moves only after a legal page-select write in mode 3
    a_r5_page_only_by_psel: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.page) |-> $past(win_wr && q.bankctl == PSEL_C && win_off == '0));

    // R7: bank number moves only after a write to the bank-switch register
    a_r7_bank_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pbank) |-> $past(bsw_wr));
endmodule

// File: rtl/vwin_fill.sv
module vwin_fill #(
    parameter int DATA_W  = 8,
    parameter int PAGE_AW = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               page_in,
    input  logic [DATA_W-1:0]  val_in,
    output logic               busy,
    output logic               fill_we,
    output logic [PAGE_AW-1:0] fill_addr,
    output logic               fill_page,
    output logic [DATA_W-1:0]  fill_val
);
    localparam logic [PAGE_AW-1:0] LAST = {PAGE_AW{1'b1}};

    typedef struct packed {
        logic               busy;
        logic [PAGE_AW-1:0] cnt;
        logic               page;
        logic [DATA_W-1:0]  val;
    } fill_t;

    fill_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.page = page_in;
                d.val  = val_in;
            end
        end else if (q.cnt == LAST) begin
            d.busy = 1'b0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign fill_we   = q.busy;
    assign fill_addr = q.cnt;
    assign fill_page = q.page;
    assign fill_val  = q.val;

    // R8: a fill only begins on a trigger
    a_r8_fill_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(start));

    // R8: consecutive busy cycles walk the page one byte at a time
    a_r8_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> (q.cnt == PAGE_AW'($past(q.cnt) + 1'b1)));

    // R8: target page and byte stay fixed for the whole fill
    a_r8_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> ($stable(q.page) && $stable(q.val)));
endmodule

// File: rtl/vwin_route.sv
module vwin_route #(
    parameter int DATA_W     = 8,
    parameter int PAGE_AW    = 13,
    parameter int AUX_AW     = 11,
    parameter int ROMSEL_W   = 7,
    parameter int ROM_OFF_AW = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         win_rd,
    input  logic                         win_wr,
    input  logic [PAGE_AW-1:0]           win_off,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [DATA_W-1:0]            bankctl,
    input  logic [DATA_W-1:0]            romsel,
    input  logic                         wen,
    input  logic                         page,
    input  logic                         psel_hit,
    input  logic                         fill_busy,
    input  logic                         fill_we,
    input  logic [PAGE_AW-1:0]           fill_addr,
    input  logic                         fill_page,
    input  logic [DATA_W-1:0]            fill_val,
    input  logic [DATA_W-1:0]            vram_rdata,
    input  logic [DATA_W-1:0]            aux_rdata,
    input  logic [DATA_W-1:0]            rom_rdata,
    output logic                         vram_page,
    output logic [PAGE_AW-1:0]           vram_addr,
    output logic                         vram_we,
    output logic [DATA_W-1:0]            vram_wdata,
    output logic [AUX_AW-1:0]            aux_addr,
    output logic                         aux_we,
    output logic [DATA_W-1:0]            aux_wdata,
    output logic [ROMSEL_W+ROM_OFF_AW-1:0] rom_addr,
    output logic [DATA_W-1:0]            cpu_rdata
);
    import vwin_pkg::*;

    localparam int AUX_DEPTH = 1 << AUX_AW;
    localparam int ROM_DEPTH = 1 << ROM_OFF_AW;
    localparam logic [DATA_W-1:0] VRAM_C = DATA_W'(MODE_VRAM);
    localparam logic [DATA_W-1:0] AUX_C  = DATA_W'(MODE_AUX);

    typedef struct packed {
        rd_src_e src;
    } route_t;

    route_t q, d;
    logic   mode_vram, mode_aux, rom_hit, cpu_wr_ok;

    always_comb begin
        d         = q;
        mode_vram = (bankctl == VRAM_C);
        mode_aux  = (bankctl == AUX_C) && (win_off < PAGE_AW'(AUX_DEPTH));
        rom_hit   = (romsel != '0) && (win_off < PAGE_AW'(ROM_DEPTH));
        cpu_wr_ok = win_wr && !psel_hit && wen;

        d.src = SRC_NONE;
        if (win_rd) begin
            if (rom_hit)        d.src = SRC_ROM;
            else if (mode_vram) d.src = fill_busy ? SRC_NONE : SRC_VRAM;
            else if (mode_aux)  d.src = SRC_AUX;
        end

        if (fill_busy) begin
            vram_page  = fill_page;
            vram_addr  = fill_addr;
            vram_we    = fill_we;
            vram_wdata = fill_val;
        end else begin
            vram_page  = page;
            vram_addr  = win_off;
            vram_we    = cpu_wr_ok && mode_vram;
            vram_wdata = wdata;
        end

        aux_addr  = win_off[AUX_AW-1:0];
        aux_wdata = wdata;
        aux_we    = cpu_wr_ok && mode_aux;
        rom_addr  = {romsel[ROMSEL_W-1:0], win_off[ROM_OFF_AW-1:0]};

        case (q.src)
            SRC_VRAM: cpu_rdata = vram_rdata;
            SRC_AUX:  cpu_rdata = aux_rdata;
            SRC_ROM:  cpu_rdata = rom_rdata;
            default:  cpu_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: a ROM-sourced read was issued with a nonzero select
    a_r2_rom_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (q.src == SRC_ROM) |-> ($past(romsel) != '0));

    // R4: auxiliary reads only come from mode 2
    a_r4_aux_read_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (q.src == SRC_AUX) |-> ($past(bankctl) == AUX_C));

    // R6: no CPU-originated RAM write while the enable bit is clear
    a_r6_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_we || (vram_we && !fill_busy)) |-> wen);

    // R10: no video read is served in a cycle after the fill owned the port
    a_r10_fill_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fill_busy) |-> (q.src != SRC_VRAM));
endmodule

// File: rtl/vwin_ctrl.sv
module vwin_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_AW    = 13,
    parameter int AUX_AW     = 11,
    parameter int ROMSEL_W   = 7,
    parameter int ROM_OFF_AW = 12,
    parameter int PBANK_W    = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 16'hDFFF,
    parameter logic [ADDR_W-1:0] BSW_ADDR = 16'hF480,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'hF500
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic [DATA_W-1:0]              cpu_wdata,
    input  logic                           cpu_rd,
    input  logic                           cpu_wr,
    output logic [DATA_W-1:0]              cpu_rdata,
    output logic [PBANK_W-1:0]             prog_bank,
    output logic                           fill_busy,
    output logic                           vram_page,
    output logic [PAGE_AW-1:0]             vram_addr,
    output logic                           vram_we,
    output logic [DATA_W-1:0]              vram_wdata,
    input  logic [DATA_W-1:0]              vram_rdata,
    output logic [AUX_AW-1:0]              aux_addr,
    output logic                           aux_we,
    output logic [DATA_W-1:0]              aux_wdata,
    input  logic [DATA_W-1:0]              aux_rdata,
    output logic [ROMSEL_W+ROM_OFF_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0]              rom_rdata
);
    logic               in_win, win_rd, win_wr, ctl_wr, bsw_wr, sel_wr;
    logic [PAGE_AW-1:0] win_off;
    logic [DATA_W-1:0]  bankctl, romsel, shd_val, fill_val;
    logic               wen, page, psel_hit, fill_start, shd_page;
    logic               fill_we, fill_page;
    logic [PAGE_AW-1:0] fill_addr;

    always_comb begin
        in_win  = (cpu_addr[ADDR_W-1:PAGE_AW] == WIN_BASE[ADDR_W-1:PAGE_AW])
                  && (cpu_addr != CTL_ADDR);
        win_off = cpu_addr[PAGE_AW-1:0];
        win_rd  = cpu_rd && in_win;
        win_wr  = cpu_wr && in_win;
        ctl_wr  = cpu_wr && (cpu_addr == CTL_ADDR);
        bsw_wr  = cpu_wr && (cpu_addr == BSW_ADDR);
        sel_wr  = cpu_wr && (cpu_addr == SEL_ADDR);
    end

    vwin_regs #(.DATA_W(DATA_W), .PAGE_AW(PAGE_AW), .AUX_AW(AUX_AW),
                .PBANK_W(PBANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .win_off(win_off),
        .ctl_wr(ctl_wr), .bsw_wr(bsw_wr), .sel_wr(sel_wr), .wdata(cpu_wdata),
        .bankctl(bankctl), .romsel(romsel), .pbank(prog_bank), .wen(wen),
        .page(page), .psel_hit(psel_hit), .fill_start(fill_start),
        .shd_page(shd_page), .shd_val(shd_val)
    );

    vwin_fill #(.DATA_W(DATA_W), .PAGE_AW(PAGE_AW)) u_fill (
        .clk(clk), .rst_n(rst_n), .start(fill_start), .page_in(shd_page),
        .val_in(shd_val), .busy(fill_busy), .fill_we(fill_we),
        .fill_addr(fill_addr), .fill_page(fill_page), .fill_val(fill_val)
    );

    vwin_route #(.DATA_W(DATA_W), .PAGE_AW(PAGE_AW), .AUX_AW(AUX_AW),
                 .ROMSEL_W(ROMSEL_W), .ROM_OFF_AW(ROM_OFF_AW)) u_route (
        .clk(clk), .rst_n(rst_n), .win_rd(win_rd), .win_wr(win_wr),
        .win_off(win_off), .wdata(cpu_wdata), .bankctl(bankctl),
        .romsel(romsel), .wen(wen), .page(page), .psel_hit(psel_hit),
        .fill_busy(fill_busy), .fill_we(fill_we), .fill_addr(fill_addr),
        .fill_page(fill_page), .fill_val(fill_val), .vram_rdata(vram_rdata),
        .aux_rdata(aux_rdata), .rom_rdata(rom_rdata), .vram_page(vram_page),
        .vram_addr(vram_addr), .vram_we(vram_we), .vram_wdata(vram_wdata),
        .aux_addr(aux_addr), .aux_we(aux_we), .aux_wdata(aux_wdata),
        .rom_addr(rom_addr), .cpu_rdata(cpu_rdata)
    );

    // R1: the mode-register write never reaches a RAM
    a_r1_ctl_write_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == CTL_ADDR && !fill_busy) |-> (!vram_we && !aux_we));
endmodule

// File: tb/tb_vwin_ctrl.sv
`timescale 1ns/1ps
module tb_vwin_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [3:0]  prog_bank;
    logic        fill_busy, vram_page, vram_we, aux_we;
    logic [12:0] vram_addr;
    logic [7:0]  vram_wdata, aux_wdata;
    logic [7:0]  vram_rdata = '0, aux_rdata = '0, rom_rdata = '0;
    logic [10:0] aux_addr;
    logic [18:0] rom_addr;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vwin_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .prog_bank(prog_bank), .fill_busy(fill_busy), .vram_page(vram_page),
        .vram_addr(vram_addr), .vram_we(vram_we), .vram_wdata(vram_wdata),
        .vram_rdata(vram_rdata), .aux_addr(aux_addr), .aux_we(aux_we),
        .aux_wdata(aux_wdata), .aux_rdata(aux_rdata), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata)
    );

    function automatic logic [7:0] rom_byte(input int a);
        return 8'(a) ^ 8'(a >> 11) ^ 8'h5C;
    endfunction

    // environment memories behind the block
    logic [7:0] env_v[int];
    logic [7:0] env_a[int];
    always @(posedge clk) begin
        int kv, ka;
        kv = int'(vram_page) * 8192 + int'(vram_addr);
        ka = int'(aux_addr);
        vram_rdata <= env_v.exists(kv) ? env_v[kv] : 8'h00;
        aux_rdata  <= env_a.exists(ka) ? env_a[ka] : 8'h00;
        rom_rdata  <= rom_byte(int'(rom_addr));
        if (vram_we) env_v[kv] = vram_wdata;
        if (aux_we)  env_a[ka] = aux_wdata;
    end

    // reference model state
    int         m_ctl = 0, m_sel = 0, m_pbank = 0, busy_cnt = 0;
    bit         m_wen = 0, m_page = 0;
    logic [7:0] m_v[int];
    logic [7:0] m_a[int];

    function automatic logic [7:0] mget(input bit aux, input int k);
        if (aux) return m_a.exists(k) ? m_a[k] : 8'h00;
        return m_v.exists(k) ? m_v[k] : 8'h00;
    endfunction

    function automatic logic [7:0] model_read(input int a, input bit busy);
        int off;
        if (a < 'hC000 || a > 'hDFFE) return 8'h00;
        off = a - 'hC000;
        if (m_sel != 0 && off < 'h1000) return rom_byte(((m_sel & 'h7F) << 12) + off);
        if (m_ctl == 0) return busy ? 8'h00 : mget(0, int'(m_page) * 8192 + off);
        if (m_ctl == 2 && off < 'h800) return mget(1, off);
        return 8'h00;
    endfunction

    task automatic model_write(input int a, input logic [7:0] d, input bit busy,
                               output bit trig);
        int off;
        trig = 0;
        if (a == 'hDFFF) m_ctl = int'(d);
        else if (a == 'hF480) begin
            m_pbank = int'(d[3:0]); m_wen = d[7]; trig = d[6];
        end else if (a == 'hF500) m_sel = int'(d);
        else if (a >= 'hC000 && a <= 'hDFFE) begin
            off = a - 'hC000;
            if (m_ctl == 3 && off == 0 && d[7:1] == 0) m_page = d[0];
            else if (m_ctl == 0 && m_wen && !busy) m_v[int'(m_page) * 8192 + off] = d;
            else if (m_ctl == 2 && off < 'h800 && m_wen) m_a[off] = d;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit rd, input bit wr, input logic [15:0] a,
                        input logic [7:0] d, input string req);
        logic [7:0] exp_rd;
        bit pre, trig;
        int pg;
        logic [7:0] val;
        pre = busy_cnt > 0;
        trig = 0;
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        exp_rd = rd ? model_read(int'(a), pre) : 8'h00;
        if (wr) model_write(int'(a), d, pre, trig);
        if (busy_cnt > 0) busy_cnt--;
        if (trig && !pre) begin
            pg  = int'(mget(1, 0) & 8'h01);
            val = mget(1, 1);
            for (int i = 0; i < 8192; i++) m_v[pg * 8192 + i] = val;
            busy_cnt = 8192;
        end
        @(posedge clk);
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0;
        check("R7 prog_bank", int'(prog_bank), m_pbank);
        check("R8 fill_busy", int'(fill_busy), int'(busy_cnt > 0));
        if (rd) check(req, int'(cpu_rdata), int'(exp_rd));
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
        step(0, 1, a, d, req);
    endtask
    task automatic rd(input logic [15:0] a, input string req);
        step(1, 0, a, 8'h00, req);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R8: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 prog_bank", int'(prog_bank), 0);
        check("R11 fill_busy", int'(fill_busy), 0);
        rd(16'hC000, "R11 read after reset");
        wr(16'hC000, 8'hAB, "R11 wen clear");
        rd(16'hC000, "R11 write dropped after reset");

        // R7 / R3
        wr(16'hF480, 8'h85, "R7");
        wr(16'hC000, 8'h11, "R3");
        wr(16'hC123, 8'h22, "R3");
        wr(16'hDFFE, 8'h33, "R3");
        rd(16'hC000, "R3 page0 low");
        rd(16'hC123, "R3 page0 mid");
        rd(16'hDFFE, "R3 page0 top");
        wr(16'hF480, 8'h8A, "R7 bank change");

        // R5 page select
        wr(16'hDFFF, 8'h03, "R1 ctl write");
        wr(16'hC000, 8'h03, "R5 illegal data");
        wr(16'hC001, 8'h01, "R5 nonzero offset");
        rd(16'hC000, "R9 mode3 read");
        wr(16'hDFFF, 8'h00, "R1");
        rd(16'hC123, "R5 still page0");
        wr(16'hDFFF, 8'h03, "R1");
        wr(16'hC000, 8'h01, "R5 select page1");
        wr(16'hDFFF, 8'h00, "R1");
        rd(16'hC123, "R5 page1 empty");
        wr(16'hC123, 8'h44, "R3 page1");
        rd(16'hC123, "R3 page1 readback");
        wr(16'hDFFF, 8'h03, "R1");
        wr(16'hC000, 8'h00, "R5 select page0");
        wr(16'hDFFF, 8'h00, "R1");
        rd(16'hC123, "R5 page0 kept");

        // R1 window edges
        rd(16'hDFFE, "R1 ctl write missed RAM");
        rd(16'hB000, "R1 outside window");
        wr(16'hBFFF, 8'h5E, "R1 outside write");
        rd(16'hC000, "R1 outside write no effect");

        // R6 write enable
        wr(16'hF480, 8'h05, "R6 disable");
        wr(16'hC000, 8'h99, "R6 vram dropped");
        rd(16'hC000, "R6 vram unchanged");
        wr(16'hDFFF, 8'h02, "R1");
        wr(16'hC010, 8'h77, "R6 aux dropped");
        rd(16'hC010, "R6 aux unchanged");
        wr(16'hF480, 8'h85, "R6 enable");
        wr(16'hC010, 8'h77, "R4");
        rd(16'hC010, "R4 aux readback");
        rd(16'hC7FF, "R4 aux top");
        rd(16'hC800, "R4 beyond aux");
        wr(16'hDFFF, 8'h01, "R1");
        rd(16'hC000, "R9 mode1 read");

        // R2 ROM view
        wr(16'hF500, 8'h83, "R2 select");
        rd(16'hC005, "R2 rom low");
        rd(16'hCFFF, "R2 rom top");
        wr(16'hDFFF, 8'h00, "R1");
        rd(16'hC000, "R2 rom over vram");
        rd(16'hD000, "R2 past rom view");
        wr(16'hF500, 8'h00, "R2 deselect");
        rd(16'hC000, "R2 rom off");

        // R8 fill, R10 blocking
        wr(16'hDFFF, 8'h02, "R1");
        wr(16'hC000, 8'h01, "R8 aux page");
        wr(16'hC001, 8'h5A, "R8 aux value");
        wr(16'hF480, 8'hC5, "R8 trigger");
        wr(16'hDFFF, 8'h00, "R1");
        rd(16'hC123, "R10 read blocked");
        wr(16'hC124, 8'h66, "R10 write dropped");
        wr(16'hF480, 8'hC5, "R8 retrigger ignored");
        for (int i = 0; i < 8200; i++) step(0, 0, 16'h0000, 8'h00, "R8");
        wr(16'hDFFF, 8'h03, "R1");
        wr(16'hC000, 8'h01, "R5");
        wr(16'hDFFF, 8'h00, "R1");
        rd(16'hC000, "R8 fill first");
        rd(16'hC124, "R8 fill over dropped write");
        rd(16'hDFFE, "R8 fill last");
        wr(16'hDFFF, 8'h03, "R1");
        wr(16'hC000, 8'h00, "R5");
        wr(16'hDFFF, 8'h00, "R1");
        rd(16'hC123, "R8 other page kept");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule